// File: doc/BRIEF.md
# Nibble-Register BCD Real-Time Clock

This block keeps calendar time as a set of binary-coded decimal digits. Each digit lives in its own 4-bit register on a small parallel bus with a 4-bit address, 4-bit data, and separate read and write strobes. A single-cycle tick pulse, expected once per second, advances the seconds. Carries ripple through minutes, hours, day of month, month and year. Day rollover follows the length of the current month, and February gains a 29th day when the year count is a multiple of four. A weekday counter steps modulo seven each time the day rolls over.

The host sets the time by writing the digit registers one at a time. Three control nibbles sit at the top of the address space. One bit in the last control nibble chooses between a 24-hour and a 12-hour view of the hour. In the 12-hour view, the hour digits show the hour modulo twelve and a PM flag is folded into the hour-tens nibble. The year is held as two digits plus a century flag. With year folding enabled, the tens digit never shows the century.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00 and weekday 0, and the control nibbles at addresses D, E and F read 1, 0 and 4.
- R2: The register addresses are fixed as follows: 0/1 hold the seconds units/tens, 2/3 the minutes units/tens, 4/5 the hours units/tens, 6/7 the day units/tens, 8/9 the month units/tens, A/B the year units/tens, C the weekday (0 to 6), and D/E/F the control nibbles.
- R3: Each tick adds one second. A digit pair that has reached 59 seconds, 59 minutes or 23 hours returns to 00 and carries into the next pair.
- R4: The day wraps to 01 and the month advances after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R5: February wraps after day 29 when the two-digit year is a multiple of four, and after day 28 otherwise.
- R6: A carry out of month 12 gives month 01 and advances the year. Months read as 1 to 12.
- R7: The weekday advances by one on every day rollover, and 6 is followed by 0.
- R8: Bit 2 of control F selects the hour format: 1 means 24-hour and 0 means 12-hour. In 12-hour format, address 4 reads the units of (hour mod 12). Address 5 reads the tens of (hour mod 12), with bit 2 set when the 24-hour value is 12 or more. In 24-hour format, the hour digits are shown as stored.
- R9: A write to control D keeps only bits 0 and 3 (mask 4'b1001) and clears the rest. Writes to E and F keep all four bits.
- R10: A digit write replaces that digit only, without any carry into its neighbours. A write in the same cycle as a tick overrides the addressed digit, while every other digit takes its ticked value.
- R11: Read data follows the address combinationally while the read strobe is high, and is 0 while the strobe is low.
- R12: With year folding (the default), a year carry out of 99 gives year 00, and the tens nibble reads 0 to 9 whatever the century flag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse that advances the time by one second |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, 0 when rd_i is low |

## Verification
The range checks on read data assume the host only writes legal BCD values: seconds and minutes below 60, hours below 24, a day that exists in the month, months 1 to 12 and weekdays 0 to 6. Without that, the weekday and month-tens bounds would not hold. The stimulus meets this by setting every time through a task that splits legal calendar values into digits. Tick is a single-cycle pulse driven on the falling edge, never held across a write that the bench still has to check.

// File: rtl/nibble_rtc_pkg.sv
package nibble_rtc_pkg;

  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;
  localparam int PAIR_W = 8;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC_U = 4'h0, A_SEC_T = 4'h1,
    A_MIN_U = 4'h2, A_MIN_T = 4'h3,
    A_HR_U  = 4'h4, A_HR_T  = 4'h5,
    A_DAY_U = 4'h6, A_DAY_T = 4'h7,
    A_MON_U = 4'h8, A_MON_T = 4'h9,
    A_YR_U  = 4'hA, A_YR_T  = 4'hB,
    A_WDAY  = 4'hC,
    A_CTL_D = 4'hD, A_CTL_E = 4'hE, A_CTL_F = 4'hF
  } reg_addr_e;

  typedef struct packed {
    nib_t sec_u;
    nib_t sec_t;
    nib_t min_u;
    nib_t min_t;
    nib_t hr_u;
    nib_t hr_t;
    nib_t day_u;
    nib_t day_t;
    nib_t mon_u;
    nib_t mon_t;
    nib_t yr_u;
    nib_t yr_t;
    nib_t wday;
    logic cent;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{
    sec_u: 4'd0, sec_t: 4'd0, min_u: 4'd0, min_t: 4'd0,
    hr_u:  4'd0, hr_t:  4'd0, day_u: 4'd1, day_t: 4'd0,
    mon_u: 4'd1, mon_t: 4'd0, yr_u:  4'd0, yr_t:  4'd0,
    wday:  4'd0, cent:  1'b0
  };

  localparam nib_t CTL_D_RST  = 4'h1;
  localparam nib_t CTL_E_RST  = 4'h0;
  localparam nib_t CTL_F_RST  = 4'h4;
  localparam nib_t CTL_D_KEEP = 4'h9;
  localparam int   FMT_BIT    = 2;
  localparam nib_t PM_FLAG    = 4'h4;

  localparam logic [PAIR_W-1:0] SEC_LAST  = 8'd59;
  localparam logic [PAIR_W-1:0] MIN_LAST  = 8'd59;
  localparam logic [PAIR_W-1:0] HR_LAST   = 8'd23;
  localparam logic [PAIR_W-1:0] MON_LAST  = 8'd12;
  localparam logic [PAIR_W-1:0] YR_LAST   = 8'd99;
  localparam nib_t                WDAY_LAST = 4'd6;

  // Binary value of a tens/units digit pair.
  function automatic logic [PAIR_W-1:0] pair_val(nib_t t, nib_t u);
    logic [PAIR_W-1:0] tw;
    tw = {{(PAIR_W-NIB_W){1'b0}}, t};
    return (tw << 3) + (tw << 1) + {{(PAIR_W-NIB_W){1'b0}}, u};
  endfunction

  // Decimal increment of a digit pair, returned as {tens, units}.
  function automatic logic [2*NIB_W-1:0] pair_inc(nib_t t, nib_t u);
    if (u >= 4'd9) return {t + 4'd1, 4'd0};
    else           return {t, u + 4'd1};
  endfunction

endpackage

// File: rtl/nibble_rtc_month_len.sv
module nibble_rtc_month_len
  import nibble_rtc_pkg::*;
(
  input  nib_t              mon_u_i,
  input  nib_t              mon_t_i,
  input  nib_t              yr_u_i,
  input  nib_t              yr_t_i,
  output logic [PAIR_W-1:0] last_day_o
);

  logic [PAIR_W-1:0] month_b;
  logic [PAIR_W-1:0] year_b;
  logic              leap;

  always_comb begin
    month_b = pair_val(mon_t_i, mon_u_i);
    year_b  = pair_val(yr_t_i, yr_u_i);
    leap    = ((year_b % 8'd4) == 8'd0);
    case (month_b)
      8'd2:                     last_day_o = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  last_day_o = 8'd30;
      default:                  last_day_o = 8'd31;
    endcase
  end

endmodule

// File: rtl/nibble_rtc_core.sv
module nibble_rtc_core
  import nibble_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  nib_t              wdata_i,
  input  logic [PAIR_W-1:0] last_day_i,
  output rtc_time_t         time_o
);

  rtc_time_t cur_q;
  rtc_time_t nxt;
  logic      load_en;

  logic sec_end, min_end, hr_end, day_end, mon_end, yr_end;

  always_comb begin
    sec_end = pair_val(cur_q.sec_t, cur_q.sec_u) >= SEC_LAST;
    min_end = pair_val(cur_q.min_t, cur_q.min_u) >= MIN_LAST;
    hr_end  = pair_val(cur_q.hr_t,  cur_q.hr_u)  >= HR_LAST;
    day_end = pair_val(cur_q.day_t, cur_q.day_u) >= last_day_i;
    mon_end = pair_val(cur_q.mon_t, cur_q.mon_u) >= MON_LAST;
    yr_end  = pair_val(cur_q.yr_t,  cur_q.yr_u)  >= YR_LAST;
  end

  // Next state: carry chain first, then the addressed digit write on top.
  always_comb begin
    nxt = cur_q;
    if (tick_i) begin
      if (!sec_end) begin
        {nxt.sec_t, nxt.sec_u} = pair_inc(cur_q.sec_t, cur_q.sec_u);
      end else begin
        {nxt.sec_t, nxt.sec_u} = '0;
        if (!min_end) begin
          {nxt.min_t, nxt.min_u} = pair_inc(cur_q.min_t, cur_q.min_u);
        end else begin
          {nxt.min_t, nxt.min_u} = '0;
          if (!hr_end) begin
            {nxt.hr_t, nxt.hr_u} = pair_inc(cur_q.hr_t, cur_q.hr_u);
          end else begin
            {nxt.hr_t, nxt.hr_u} = '0;
            nxt.wday = (cur_q.wday >= WDAY_LAST) ? 4'd0 : cur_q.wday + 4'd1;
            if (!day_end) begin
              {nxt.day_t, nxt.day_u} = pair_inc(cur_q.day_t, cur_q.day_u);
            end else begin
              nxt.day_t = 4'd0;
              nxt.day_u = 4'd1;
              if (!mon_end) begin
                {nxt.mon_t, nxt.mon_u} = pair_inc(cur_q.mon_t, cur_q.mon_u);
              end else begin
                nxt.mon_t = 4'd0;
                nxt.mon_u = 4'd1;
                if (!yr_end) begin
                  {nxt.yr_t, nxt.yr_u} = pair_inc(cur_q.yr_t, cur_q.yr_u);
                end else begin
                  {nxt.yr_t, nxt.yr_u} = '0;
                  nxt.cent = ~cur_q.cent;
                end
              end
            end
          end
        end
      end
    end
    if (wr_i) begin
      case (addr_i)
        A_SEC_U: nxt.sec_u = wdata_i;
        A_SEC_T: nxt.sec_t = wdata_i;
        A_MIN_U: nxt.min_u = wdata_i;
        A_MIN_T: nxt.min_t = wdata_i;
        A_HR_U:  nxt.hr_u  = wdata_i;
        A_HR_T:  nxt.hr_t  = wdata_i;
        A_DAY_U: nxt.day_u = wdata_i;
        A_DAY_T: nxt.day_t = wdata_i;
        A_MON_U: nxt.mon_u = wdata_i;
        A_MON_T: nxt.mon_t = wdata_i;
        A_YR_U:  nxt.yr_u  = wdata_i;
        A_YR_T:  nxt.yr_t  = wdata_i;
        A_WDAY:  nxt.wday  = wdata_i;
        default: ;
      endcase
    end
  end

  assign load_en = tick_i | wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= TIME_RST;
    end else if (load_en) begin
      cur_q <= nxt;
    end
  end

  assign time_o = cur_q;

endmodule

// File: rtl/nibble_rtc_ctrl.sv
module nibble_rtc_ctrl
  import nibble_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  nib_t              wdata_i,
  output nib_t              ctl_d_o,
  output nib_t              ctl_e_o,
  output nib_t              ctl_f_o
);

  nib_t ctl_d_q, ctl_e_q, ctl_f_q;
  nib_t ctl_d_n, ctl_e_n, ctl_f_n;
  logic ctl_en;

  always_comb begin
    ctl_d_n = ctl_d_q;
    ctl_e_n = ctl_e_q;
    ctl_f_n = ctl_f_q;
    ctl_en  = 1'b0;
    if (wr_i) begin
      case (addr_i)
        A_CTL_D: begin ctl_d_n = wdata_i & CTL_D_KEEP; ctl_en = 1'b1; end
        A_CTL_E: begin ctl_e_n = wdata_i;              ctl_en = 1'b1; end
        A_CTL_F: begin ctl_f_n = wdata_i;              ctl_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_d_q <= CTL_D_RST;
      ctl_e_q <= CTL_E_RST;
      ctl_f_q <= CTL_F_RST;
    end else if (ctl_en) begin
      ctl_d_q <= ctl_d_n;
      ctl_e_q <= ctl_e_n;
      ctl_f_q <= ctl_f_n;
    end
  end

  assign ctl_d_o = ctl_d_q;
  assign ctl_e_o = ctl_e_q;
  assign ctl_f_o = ctl_f_q;

endmodule

// File: rtl/nibble_rtc_rdmux.sv
module nibble_rtc_rdmux
  import nibble_rtc_pkg::*;
#(
  parameter bit YEAR_FOLD = 1'b1
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  rtc_time_t         time_i,
  input  nib_t              ctl_d_i,
  input  nib_t              ctl_e_i,
  input  nib_t              ctl_f_i,
  output nib_t              rdata_o
);

  logic [PAIR_W-1:0] hr_b;
  logic [PAIR_W-1:0] h12_b;
  logic              pm;
  nib_t              hr_u_v, hr_t_v, yr_t_v;
  nib_t              sel;

  // 12-hour view is derived on the read path; storage stays 24-hour.
  always_comb begin
    hr_b  = pair_val(time_i.hr_t, time_i.hr_u);
    pm    = hr_b >= 8'd12;
    h12_b = pm ? hr_b - 8'd12 : hr_b;
    if (ctl_f_i[FMT_BIT]) begin
      hr_u_v = time_i.hr_u;
      hr_t_v = time_i.hr_t;
    end else if (h12_b >= 8'd10) begin
      hr_u_v = NIB_W'(h12_b - 8'd10);
      hr_t_v = 4'd1 | (pm ? PM_FLAG : 4'd0);
    end else begin
      hr_u_v = NIB_W'(h12_b);
      hr_t_v = pm ? PM_FLAG : 4'd0;
    end
    yr_t_v = (YEAR_FOLD || !time_i.cent) ? time_i.yr_t : time_i.yr_t + 4'd10;
  end

  always_comb begin
    case (addr_i)
      A_SEC_U: sel = time_i.sec_u;
      A_SEC_T: sel = time_i.sec_t;
      A_MIN_U: sel = time_i.min_u;
      A_MIN_T: sel = time_i.min_t;
      A_HR_U:  sel = hr_u_v;
      A_HR_T:  sel = hr_t_v;
      A_DAY_U: sel = time_i.day_u;
      A_DAY_T: sel = time_i.day_t;
      A_MON_U: sel = time_i.mon_u;
      A_MON_T: sel = time_i.mon_t;
      A_YR_U:  sel = time_i.yr_u;
      A_YR_T:  sel = yr_t_v;
      A_WDAY:  sel = time_i.wday;
      A_CTL_D: sel = ctl_d_i;
      A_CTL_E: sel = ctl_e_i;
      default: sel = ctl_f_i;
    endcase
    rdata_o = rd_i ? sel : '0;
  end

endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import nibble_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit YEAR_FOLD   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  rdata_o
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  rtc_time_t              time_q;
  logic [PAIR_W-1:0]      last_day;
  nib_t                   ctl_d_q, ctl_e_q, ctl_f_q;

  // Reset asserts at once and releases after SYNC_STAGES clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  nibble_rtc_month_len u_mlen (
    .mon_u_i    (time_q.mon_u),
    .mon_t_i    (time_q.mon_t),
    .yr_u_i     (time_q.yr_u),
    .yr_t_i     (time_q.yr_t),
    .last_day_o (last_day)
  );

  nibble_rtc_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .tick_i     (tick_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .last_day_i (last_day),
    .time_o     (time_q)
  );

  nibble_rtc_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ctl_d_o (ctl_d_q),
    .ctl_e_o (ctl_e_q),
    .ctl_f_o (ctl_f_q)
  );

  nibble_rtc_rdmux #(.YEAR_FOLD(YEAR_FOLD)) u_rdmux (
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .time_i  (time_q),
    .ctl_d_i (ctl_d_q),
    .ctl_e_i (ctl_e_q),
    .ctl_f_i (ctl_f_q),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/nibble_rtc_chk.sv
module nibble_rtc_chk
  import nibble_rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NIB_W-1:0]  wdata_i,
  input logic [NIB_W-1:0]  rdata_o,
  input rtc_time_t         time_q,
  input nib_t              ctl_d_q,
  input nib_t              ctl_f_q
);

  // R11: idle read strobe drives zero
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 4'd0);

  // R9: control D keeps only its two live bits
  a_r9_ctl_d_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTL_D) |=> ctl_d_q == ($past(wdata_i) & CTL_D_KEEP));

  // R3: seconds wrap from 59 to 00 on a tick
  a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && time_q.sec_t == 4'd5 && time_q.sec_u == 4'd9)
    |=> (time_q.sec_t == 4'd0 && time_q.sec_u == 4'd0));

  // R10: time holds without tick or write
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(time_q));

  // R8: 12-hour tens nibble carries only a 0/1 digit and the PM flag
  a_r8_hour12_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_HR_T && !ctl_f_q[FMT_BIT]) |-> (rdata_o & 4'hA) == 4'd0);

  // R7: weekday stays within 0..6 given legal writes
  a_r7_wday_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_WDAY) |-> rdata_o < 4'd7);

  // R6: month tens is 0 or 1 given legal writes
  a_r6_mon_tens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_MON_T) |-> rdata_o <= 4'd1);

endmodule

bind nibble_rtc nibble_rtc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .tick_i  (tick_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .time_q  (time_q),
  .ctl_d_q (ctl_d_q),
  .ctl_f_q (ctl_f_q)
);

// File: tb/nibble_rtc_test.sv
`timescale 1ns/1ps
module nibble_rtc_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, wr, rd;
  logic [3:0] addr, wdata;
  logic [3:0] rdata;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  nibble_rtc uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .wr_i    (wr),
    .rd_i    (rd),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [3:0] exp, input string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, rdata, exp);
    end
    rd = 1'b0;
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input int yr, input int mo, input int dy, input int hr,
                          input int mi, input int sc, input int wd);
    wr_reg(4'h0, 4'(sc % 10)); wr_reg(4'h1, 4'(sc / 10));
    wr_reg(4'h2, 4'(mi % 10)); wr_reg(4'h3, 4'(mi / 10));
    wr_reg(4'h4, 4'(hr % 10)); wr_reg(4'h5, 4'(hr / 10));
    wr_reg(4'h6, 4'(dy % 10)); wr_reg(4'h7, 4'(dy / 10));
    wr_reg(4'h8, 4'(mo % 10)); wr_reg(4'h9, 4'(mo / 10));
    wr_reg(4'hA, 4'(yr % 10)); wr_reg(4'hB, 4'(yr / 10));
    wr_reg(4'hC, 4'(wd));
  endtask

  task automatic expect_time(input int yr, input int mo, input int dy, input int hr,
                             input int mi, input int sc, input int wd, input string tag);
    chk_reg(4'h0, 4'(sc % 10), tag); chk_reg(4'h1, 4'(sc / 10), tag);
    chk_reg(4'h2, 4'(mi % 10), tag); chk_reg(4'h3, 4'(mi / 10), tag);
    chk_reg(4'h4, 4'(hr % 10), tag); chk_reg(4'h5, 4'(hr / 10), tag);
    chk_reg(4'h6, 4'(dy % 10), tag); chk_reg(4'h7, 4'(dy / 10), tag);
    chk_reg(4'h8, 4'(mo % 10), tag); chk_reg(4'h9, 4'(mo / 10), tag);
    chk_reg(4'hA, 4'(yr % 10), tag); chk_reg(4'hB, 4'(yr / 10), tag);
    chk_reg(4'hC, 4'(wd), tag);
  endtask

  // R1, R2: reset contents at every address
  task automatic t_reset;
    expect_time(0, 1, 1, 0, 0, 0, 0, "R1 R2 reset time");
    chk_reg(4'hD, 4'h1, "R1 ctl D");
    chk_reg(4'hE, 4'h0, "R1 ctl E");
    chk_reg(4'hF, 4'h4, "R1 ctl F");
  endtask

  // R3, R6, R7: second carries all the way into the year
  task automatic t_carry_chain;
    set_time(24, 12, 31, 23, 59, 58, 6);
    pulse_ticks(1);
    expect_time(24, 12, 31, 23, 59, 59, 6, "R3 plain tick");
    pulse_ticks(1);
    expect_time(25, 1, 1, 0, 0, 0, 0, "R3 R6 R7 full carry");
    set_time(25, 3, 5, 9, 59, 59, 2);
    pulse_ticks(1);
    expect_time(25, 3, 5, 10, 0, 0, 2, "R3 hour digit carry");
  endtask

  // R4: thirty and thirty-one day months
  task automatic t_month_len;
    set_time(25, 4, 30, 23, 59, 59, 3);
    pulse_ticks(1);
    expect_time(25, 5, 1, 0, 0, 0, 4, "R4 april ends at 30");
    set_time(25, 1, 30, 23, 59, 59, 1);
    pulse_ticks(1);
    expect_time(25, 1, 31, 0, 0, 0, 2, "R4 january has 31");
    set_time(25, 11, 30, 23, 59, 59, 0);
    pulse_ticks(1);
    expect_time(25, 12, 1, 0, 0, 0, 1, "R4 november ends at 30");
  endtask

  // R5: february with and without leap year
  task automatic t_february;
    set_time(24, 2, 28, 23, 59, 59, 5);
    pulse_ticks(1);
    expect_time(24, 2, 29, 0, 0, 0, 6, "R5 leap day");
    set_time(24, 2, 29, 23, 59, 59, 6);
    pulse_ticks(1);
    expect_time(24, 3, 1, 0, 0, 0, 0, "R5 leap end");
    set_time(23, 2, 28, 23, 59, 59, 2);
    pulse_ticks(1);
    expect_time(23, 3, 1, 0, 0, 0, 3, "R5 common year");
  endtask

  // R8: 12-hour view of the hour digits
  task automatic t_hour_format;
    wr_reg(4'hF, 4'h0);
    wr_reg(4'h4, 4'd3); wr_reg(4'h5, 4'd1);           // 13h
    chk_reg(4'h4, 4'd1, "R8 13h units");
    chk_reg(4'h5, 4'd4, "R8 13h tens+PM");
    wr_reg(4'h4, 4'd3); wr_reg(4'h5, 4'd2);           // 23h
    chk_reg(4'h4, 4'd1, "R8 23h units");
    chk_reg(4'h5, 4'd5, "R8 23h tens+PM");
    wr_reg(4'h4, 4'd2); wr_reg(4'h5, 4'd1);           // 12h
    chk_reg(4'h4, 4'd0, "R8 noon units");
    chk_reg(4'h5, 4'd4, "R8 noon PM");
    wr_reg(4'h4, 4'd1); wr_reg(4'h5, 4'd1);           // 11h
    chk_reg(4'h4, 4'd1, "R8 11h units");
    chk_reg(4'h5, 4'd1, "R8 11h AM tens");
    wr_reg(4'h4, 4'd0); wr_reg(4'h5, 4'd0);           // 0h
    chk_reg(4'h5, 4'd0, "R8 midnight tens");
    wr_reg(4'hF, 4'h4);
    wr_reg(4'h4, 4'd3); wr_reg(4'h5, 4'd1);
    chk_reg(4'h4, 4'd3, "R8 24h units");
    chk_reg(4'h5, 4'd1, "R8 24h tens");
  endtask

  // R9: control write masks
  task automatic t_ctrl;
    wr_reg(4'hD, 4'hF); chk_reg(4'hD, 4'h9, "R9 D keeps bits 0,3");
    wr_reg(4'hD, 4'h6); chk_reg(4'hD, 4'h0, "R9 D clears bits 1,2");
    wr_reg(4'hE, 4'hA); chk_reg(4'hE, 4'hA, "R9 E full");
    wr_reg(4'hF, 4'hF); chk_reg(4'hF, 4'hF, "R9 F full");
    wr_reg(4'hF, 4'h4); chk_reg(4'hF, 4'h4, "R9 F restore");
  endtask

  // R10: direct digit writes, and write racing a tick
  task automatic t_write;
    set_time(25, 6, 15, 10, 20, 30, 3);
    wr_reg(4'h1, 4'd5); wr_reg(4'h0, 4'd9);
    chk_reg(4'h0, 4'd9, "R10 sec units written");
    chk_reg(4'h2, 4'd0, "R10 no carry into minutes");
    chk_reg(4'h3, 4'd2, "R10 minutes tens untouched");
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 4'h2; wdata = 4'd7;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    expect_time(25, 6, 15, 10, 27, 0, 3, "R10 write over tick");
  endtask

  // R11: idle strobe reads zero
  task automatic t_idle_read;
    @(negedge clk); rd = 1'b0; addr = 4'hF;
    #1; checks++;
    if (rdata !== 4'd0) begin
      errors++;
      $display("FAIL R11 idle read: got %h expected 0", rdata);
    end
  endtask

  // R12: century carry with year folding
  task automatic t_year_wrap;
    set_time(99, 12, 31, 23, 59, 59, 4);
    pulse_ticks(1);
    expect_time(0, 1, 1, 0, 0, 0, 5, "R12 year folds to 00");
    pulse_ticks(3);
    chk_reg(4'hB, 4'd0, "R12 tens stays below 10");
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_carry_chain();
    t_month_len();
    t_february();
    t_hour_format();
    t_ctrl();
    t_write();
    t_idle_read();
    t_year_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule